// File: doc/BRIEF.md
# User/Monitor Mode Switch with System Call Sequencer

This block decides, instruction by instruction, which privilege mode the processor runs in next and where it fetches next. Every instruction it accepts from the issue stage arrives with its own program counter, the branch outcome and two event lines, an external interrupt and a protection trap. For each accepted instruction the block emits exactly one next-PC pulse. When that instruction leaves user mode or enters it, the mode output changes in the same cycle as the next PC, so the first fetch after the switch already runs in the new mode.

There are three ways from user mode into monitor mode. One is a protection trap, and a privileged opcode issued in user mode counts as one. Another is an external interrupt. The third is a system call instruction, which may also be issued from monitor mode. For a system call, the block writes a link word to absolute address zero through a valid/ready write port, and then dispatches to one of 64 vectors selected by the instruction's 6-bit operation field. The way back to user mode is a taken branch, executed in monitor mode, whose target is marked as mapped. An indirect branch through the link word is exactly such a branch.

The instruction input is a valid/ready stream. `instr_ready` falls from the cycle after a system call is accepted and stays low until the link write completes. The write port holds `mem_wr_valid`, address and data steady until `mem_wr_ready` is seen high at a clock edge, and nothing new is accepted meanwhile. The event and branch inputs are only looked at while `instr_valid && instr_ready` is high.

Top module: `mode_switch_seq`

## Requirements
- R1: After reset the block is in monitor mode (`user_mode`=0), with `npc_valid`=0, `mem_wr_valid`=0 and `instr_ready`=1.
- R2: An instruction word with bits [23:22]=2'b01 is a system call, and its bits [21:16] hold the operation number. Once the link write completes, `npc` = VEC_BASE (default 64) + operation, `user_mode`=0, and `npc_valid` pulses on the clock edge that follows the write handshake.
- R3: The link write of a system call goes to address 0. Its data carries the calling PC in bits [13:0] and a 1 in bit 14 (indirect flag). Bit 15 is 1 exactly when the call was issued in user mode, and bits [23:16] are zero. The write is valid from the clock edge that accepts the call.
- R4: While a link write waits for `mem_wr_ready`, `mem_wr_valid` stays high with data unchanged, `instr_ready` is 0, no other instruction is taken and no `npc_valid` pulse appears.
- R5: A `trap_req` accepted in user mode gives `npc` = TRAP_VEC (default 20) and monitor mode. In monitor mode `trap_req` has no effect.
- R6: In user mode, an instruction with bits [23:22]=2'b00 and operation field at or above PRIV_MIN (default 56) raises a trap, exactly as in R5. In monitor mode the same instruction runs as a plain one.
- R7: An `irq` accepted in user mode gives `npc` = IRQ_VEC (default 30) and monitor mode. In monitor mode `irq` has no effect.
- R8: When several events coincide in user mode, the order is trap, then interrupt, then system call. The losing events start no link write and no second transition.
- R9: In monitor mode, a taken branch with `br_mapped`=1 sets `npc` to the target and `user_mode` to 1. An unmapped branch only sets `npc` to the target.
- R10: Every other accepted instruction gives one `npc_valid` pulse on the next clock edge, with `npc` = PC+1 (or the target if `br_taken`), and leaves the mode unchanged. The mode changes only on a clock edge that also raises `npc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Instruction can be accepted |
| instr_word | input | 24 | Instruction word |
| instr_pc | input | 14 | Address of the offered instruction |
| br_taken | input | 1 | Instruction is a taken branch |
| br_mapped | input | 1 | Branch target is in mapped (user) space |
| br_target | input | 14 | Branch target address |
| trap_req | input | 1 | Protection trap for this instruction |
| irq | input | 1 | External interrupt pending |
| mem_wr_valid | output | 1 | Link write request |
| mem_wr_ready | input | 1 | Memory takes the write |
| mem_wr_addr | output | 14 | Link write address (always 0) |
| mem_wr_data | output | 24 | Link word |
| npc_valid | output | 1 | Next PC pulse |
| npc | output | 14 | Next PC |
| user_mode | output | 1 | 1 = user mode, 0 = monitor mode |

## Verification
A wrong mode bit shows at the port one cycle after the offending instruction is accepted, either as a wrong `user_mode` or as an `npc` vector that does not match the event. It also shows later, because mode decides whether the next interrupt or privileged opcode is honoured. If the pending-vector register or the link state is corrupted, the damage appears in two places: as wrong link-word data or flag bits for as long as the write is stalled, and as a wrong dispatch `npc` on the edge after the handshake. If the busy state is lost, `instr_ready` rises while `mem_wr_valid` is still high, which is visible in the same cycle.

// File: rtl/mode_seq_pkg.sv
package mode_seq_pkg;
  localparam int TAG_HI = 23;
  localparam int TAG_LO = 22;
  localparam int OPF_HI = 21;
  localparam int OPF_LO = 16;
  localparam logic [1:0] TAG_CALL  = 2'b01;
  localparam logic [1:0] TAG_PLAIN = 2'b00;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_TRAP,
    EV_IRQ,
    EV_CALL,
    EV_RETURN
  } ev_e;
endpackage

// File: rtl/instr_classifier.sv
module instr_classifier #(
  parameter int OP_W     = 6,
  parameter int PRIV_MIN = 56
) (
  input  logic [1:0]      tag,
  input  logic [OP_W-1:0] op,
  output logic            is_call,
  output logic            is_priv
);
  import mode_seq_pkg::*;
  localparam logic [OP_W-1:0] PRIV_LIM = OP_W'(PRIV_MIN);

  always_comb begin
    is_call = (tag == TAG_CALL);
    is_priv = (tag == TAG_PLAIN) && (op >= PRIV_LIM);
  end
endmodule

// File: rtl/event_arbiter.sv
module event_arbiter (
  input  logic                  user_mode,
  input  logic                  trap_req,
  input  logic                  irq,
  input  logic                  is_call,
  input  logic                  is_priv,
  input  logic                  br_taken,
  input  logic                  br_mapped,
  output mode_seq_pkg::ev_e     ev
);
  import mode_seq_pkg::*;

  always_comb begin
    ev = EV_NONE;
    if (user_mode) begin
      if (trap_req || is_priv) ev = EV_TRAP;
      else if (irq)            ev = EV_IRQ;
      else if (is_call)        ev = EV_CALL;
    end else begin
      if (is_call)                     ev = EV_CALL;
      else if (br_taken && br_mapped)  ev = EV_RETURN;
    end
  end
endmodule

// File: rtl/link_writer.sv
module link_writer #(
  parameter int WORD_W = 24,
  parameter int PC_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PC_W-1:0]   call_pc,
  input  logic              from_user,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_data,
  output logic              done
);
  localparam int IND_BIT = PC_W;
  localparam int USR_BIT = PC_W + 1;
  localparam int PAD_W   = WORD_W - PC_W - 2;

  assign done = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_data  <= {{PAD_W{1'b0}}, from_user, 1'b1, call_pc};
    end else if (done) begin
      wr_valid <= 1'b0;
    end
  end

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));
  assert_indirect_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> wr_data[IND_BIT] && (wr_data[USR_BIT] == $past(from_user)));
endmodule

// File: rtl/mode_switch_seq.sv
module mode_switch_seq #(
  parameter int WORD_W   = 24,
  parameter int PC_W     = 14,
  parameter int OP_W     = 6,
  parameter int PRIV_MIN = 56,
  parameter int VEC_BASE = 64,
  parameter int TRAP_VEC = 20,
  parameter int IRQ_VEC  = 30,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [PC_W-1:0]   instr_pc,
  input  logic              br_taken,
  input  logic              br_mapped,
  input  logic [PC_W-1:0]   br_target,
  input  logic              trap_req,
  input  logic              irq,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [PC_W-1:0]   mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              npc_valid,
  output logic [PC_W-1:0]   npc,
  output logic              user_mode
);
  import mode_seq_pkg::*;

  localparam logic [PC_W-1:0] BASE_A = PC_W'(VEC_BASE);
  localparam logic [PC_W-1:0] TRAP_A = PC_W'(TRAP_VEC);
  localparam logic [PC_W-1:0] IRQ_A  = PC_W'(IRQ_VEC);

  logic            accept, is_call, is_priv, wr_done;
  logic [OP_W-1:0] op;
  logic [1:0]      tag;
  logic [PC_W-1:0] pend_vec;
  ev_e             ev;
  logic            unused_bits;

  assign tag         = instr_word[TAG_HI:TAG_LO];
  assign op          = instr_word[OPF_LO+OP_W-1:OPF_LO];
  assign unused_bits = ^instr_word[OPF_LO-1:0];
  assign instr_ready = !mem_wr_valid;
  assign accept      = instr_valid && instr_ready;
  assign mem_wr_addr = '0;

  instr_classifier #(.OP_W(OP_W), .PRIV_MIN(PRIV_MIN)) u_cls (
    .tag(tag), .op(op), .is_call(is_call), .is_priv(is_priv));

  event_arbiter u_arb (
    .user_mode(user_mode), .trap_req(trap_req), .irq(irq),
    .is_call(is_call), .is_priv(is_priv),
    .br_taken(br_taken), .br_mapped(br_mapped), .ev(ev));

  link_writer #(.WORD_W(WORD_W), .PC_W(PC_W)) u_link (
    .clk(clk), .rst_n(rst_n),
    .load(accept && ev == EV_CALL),
    .call_pc(instr_pc), .from_user(user_mode),
    .wr_ready(mem_wr_ready), .wr_valid(mem_wr_valid),
    .wr_data(mem_wr_data), .done(wr_done));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      npc_valid <= 1'b0;
      npc       <= PC_W'(RESET_PC);
      user_mode <= 1'b0;
      pend_vec  <= '0;
    end else begin
      npc_valid <= 1'b0;
      if (wr_done) begin
        npc       <= pend_vec;
        user_mode <= 1'b0;
        npc_valid <= 1'b1;
      end else if (accept) begin
        unique case (ev)
          EV_TRAP: begin
            npc <= TRAP_A; user_mode <= 1'b0; npc_valid <= 1'b1;
          end
          EV_IRQ: begin
            npc <= IRQ_A; user_mode <= 1'b0; npc_valid <= 1'b1;
          end
          EV_CALL: pend_vec <= BASE_A + PC_W'(op);
          EV_RETURN: begin
            npc <= br_target; user_mode <= 1'b1; npc_valid <= 1'b1;
          end
          default: begin
            npc       <= br_taken ? br_target : instr_pc + 1'b1;
            npc_valid <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_mode_with_npc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode != $past(user_mode)) |-> npc_valid);
  assert_dispatch_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ready |=> npc_valid && !user_mode);
  assert_busy_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !instr_ready);
  assert_trap_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && user_mode && trap_req |=> npc_valid && npc == TRAP_A && !user_mode && !mem_wr_valid);
  assert_monitor_irq_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !user_mode && !is_call && !br_taken |=> !user_mode && npc == $past(instr_pc) + 1'b1);
endmodule

// File: tb/mode_switch_seq_tb.sv
module mode_switch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VB = 64, TV = 20, IV = 30;

  logic clk = 0, rst_n = 0;
  logic instr_valid = 0, instr_ready;
  logic [23:0] instr_word = 0;
  logic [13:0] instr_pc = 0, br_target = 0;
  logic br_taken = 0, br_mapped = 0, trap_req = 0, irq = 0;
  logic mem_wr_valid, mem_wr_ready = 1;
  logic [13:0] mem_wr_addr, npc;
  logic [23:0] mem_wr_data;
  logic npc_valid, user_mode;
  int total = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_switch_seq u_dut (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL R10 watchdog actual=%0d expected<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(logic [1:0] tg, logic [5:0] o, logic [13:0] a);
    return {tg, o, 2'b00, a};
  endfunction

  // offer one instruction for one cycle, then sample after the accepting edge
  task automatic issue(logic [23:0] w, logic [13:0] pc, logic bt, logic bm,
                       logic [13:0] tgt, logic tr, logic iq);
    @(negedge clk);
    instr_valid = 1; instr_word = w; instr_pc = pc; br_taken = bt; br_mapped = bm;
    br_target = tgt; trap_req = tr; irq = iq;
    @(negedge clk);
    instr_valid = 0; br_taken = 0; br_mapped = 0; trap_req = 0; irq = 0;
  endtask

  task automatic go_user(logic [13:0] tgt);
    issue(mk(2'b10, 6'd0, 0), 14'd5, 1, 1, tgt, 0, 0);
    chk("R9 enter user", user_mode, 1);
    chk("R9 target", npc, tgt);
  endtask

  task automatic t_reset;
    chk("R1 mode", user_mode, 0);
    chk("R1 npc_valid", npc_valid, 0);
    chk("R1 wr_valid", mem_wr_valid, 0);
    chk("R1 ready", instr_ready, 1);
  endtask

  task automatic t_plain;
    issue(mk(2'b10, 6'd3, 0), 14'd100, 0, 0, 0, 0, 0);
    chk("R10 npc_valid", npc_valid, 1);
    chk("R10 pc+1", npc, 101);
    chk("R10 mode kept", user_mode, 0);
    @(negedge clk);
    chk("R10 single pulse", npc_valid, 0);
    issue(mk(2'b10, 6'd3, 0), 14'd200, 1, 0, 14'd777, 0, 0);
    chk("R9 unmapped branch target", npc, 777);
    chk("R9 unmapped stays monitor", user_mode, 0);
  endtask

  task automatic t_call_user;
    go_user(14'd1000);
    issue(mk(2'b01, 6'd13, 14'd55), 14'd1234, 0, 0, 0, 0, 0);
    chk("R3 wr_valid", mem_wr_valid, 1);
    chk("R3 addr", mem_wr_addr, 0);
    chk("R3 data", mem_wr_data, (1 << 15) | (1 << 14) | 1234);
    chk("R4 no pulse yet", npc_valid, 0);
    @(negedge clk);
    chk("R2 npc_valid", npc_valid, 1);
    chk("R2 vector", npc, VB + 13);
    chk("R2 monitor", user_mode, 0);
    chk("R2 write done", mem_wr_valid, 0);
  endtask

  task automatic t_call_monitor;
    issue(mk(2'b01, 6'd63, 0), 14'd42, 0, 0, 0, 0, 0);
    chk("R3 monitor caller data", mem_wr_data, (1 << 14) | 42);
    @(negedge clk);
    chk("R2 vector 63", npc, VB + 63);
  endtask

  task automatic t_backpressure;
    mem_wr_ready = 0;
    issue(mk(2'b01, 6'd7, 0), 14'd300, 0, 0, 0, 0, 0);
    instr_valid = 1; instr_word = mk(2'b01, 6'd9, 0); instr_pc = 14'd301;
    for (int i = 0; i < 3; i++) begin
      chk("R4 held valid", mem_wr_valid, 1);
      chk("R4 stable data", mem_wr_data, (1 << 14) | 300);
      chk("R4 ready low", instr_ready, 0);
      chk("R4 no pulse", npc_valid, 0);
      @(negedge clk);
    end
    instr_valid = 0;
    mem_wr_ready = 1;
    @(negedge clk);
    chk("R4 pulse after handshake", npc_valid, 1);
    chk("R4 first call vector", npc, VB + 7);
    chk("R4 blocked call not taken", mem_wr_valid, 0);
  endtask

  task automatic t_trap;
    go_user(14'd50);
    issue(mk(2'b10, 6'd1, 0), 14'd51, 0, 0, 0, 1, 0);
    chk("R5 vector", npc, TV);
    chk("R5 monitor", user_mode, 0);
    issue(mk(2'b10, 6'd1, 0), 14'd60, 0, 0, 0, 1, 0);
    chk("R5 ignored in monitor", npc, 61);
  endtask

  task automatic t_priv;
    go_user(14'd70);
    issue(mk(2'b00, 6'd56, 0), 14'd71, 0, 0, 0, 0, 0);
    chk("R6 priv traps", npc, TV);
    chk("R6 monitor", user_mode, 0);
    go_user(14'd80);
    issue(mk(2'b00, 6'd55, 0), 14'd81, 0, 0, 0, 0, 0);
    chk("R6 op 55 plain", npc, 82);
    chk("R6 op 55 stays user", user_mode, 1);
    issue(mk(2'b00, 6'd60, 0), 14'd90, 0, 0, 0, 0, 0);
    issue(mk(2'b00, 6'd60, 0), 14'd95, 0, 0, 0, 0, 0);
    chk("R6 priv runs in monitor", npc, 96);
  endtask

  task automatic t_irq;
    go_user(14'd110);
    issue(mk(2'b10, 6'd2, 0), 14'd111, 0, 0, 0, 0, 1);
    chk("R7 vector", npc, IV);
    chk("R7 monitor", user_mode, 0);
    issue(mk(2'b10, 6'd2, 0), 14'd120, 0, 0, 0, 0, 1);
    chk("R7 ignored in monitor", npc, 121);
  endtask

  task automatic t_priority;
    go_user(14'd130);
    issue(mk(2'b01, 6'd4, 0), 14'd131, 0, 0, 0, 1, 1);
    chk("R8 trap wins", npc, TV);
    chk("R8 no write on trap", mem_wr_valid, 0);
    go_user(14'd140);
    issue(mk(2'b01, 6'd4, 0), 14'd141, 0, 0, 0, 0, 1);
    chk("R8 irq beats call", npc, IV);
    chk("R8 no write on irq", mem_wr_valid, 0);
    @(negedge clk);
    chk("R8 single transition", npc_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_plain;
    t_call_user;
    t_call_monitor;
    t_backpressure;
    t_trap;
    t_priv;
    t_irq;
    t_priority;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule